// File: doc/BRIEF.md
# Tagged Address Translation Buffer

This block is a fully associative cache of page translations. Each slot holds a virtual page tag, a partition number, a context number, a real-address flag, a two-bit page-size code, a physical page base, and lock, valid and used flags. A lookup compares an address and its qualifiers against every slot in parallel. In the same cycle it returns a hit flag and the physical address, which is the slot's page base joined with the page offset of the request.

The block is written through an insert port and cleared through a command port. An insert can name its slot, or it can let the block choose a victim from the used flags. Victim choice is a one-bit pseudo-LRU: a slot's used flag is set when it is written or hit, and all the flags are wiped together once every slot carries one. Locked slots keep their flag through that wipe. The command port takes a packed command word and invalidates one page, one context, or a whole partition. A separate invalidate input empties the buffer. A diagnostic port returns the packed tag of any slot.

Page sizes are encoded as 0 = 8 KB, 1 = 64 KB, 2 = 4 MB and 3 = 256 MB. The offset widths are 13, 16, 22 and 28 bits.

Top module: `xlate_buf`

## Requirements
- R1: After reset, and in the cycle after `flush` is high, no lookup hits.
- R2: A lookup hits when a valid slot has the same partition, context and real flag, and its virtual address equals the request above the slot's page offset. `lk_pa` is the slot's physical base above the offset, ORed with the request's offset bits (13/16/22/28 bits for size codes 0/1/2/3). On a miss, `lk_pa` is zero.
- R3: An automatic insert (`ins_auto`=1) writes the lowest-numbered slot that is invalid or has a clear used flag. If no slot qualifies, it writes the last slot.
- R4: An insert with `ins_auto`=0 writes the slot given by `ins_idx`.
- R5: An insert invalidates every other valid slot that has the same partition, context and real flag and whose address range overlaps the new page. It also clears their used flags.
- R6: An inserted slot and a slot hit by a lookup get their used flag set. If that leaves every used flag set, all used flags of unlocked slots are cleared, except the flag of the slot just written or hit.
- R7: A demap command with operation field `dm_word[7:6]`=0 invalidates a valid slot whose partition equals `dm_part`, whose real flag equals `dm_word[9]`, whose context equals the selected context, and whose page holds the address `dm_word`.
- R8: Operation 1 invalidates every slot whose partition and context both equal the command's.
- R9: Operation 2 invalidates every unlocked slot of partition `dm_part`, whatever the context select.
- R10: Context select `dm_word[5:4]` chooses 0 = `dm_pri_ctx`, 1 = `dm_sec_ctx`, 3 = context zero. Select 2 turns operations 0 and 1 into no-ops. Operation 3 has no effect.
- R11: `rd_tag` for slot `rd_idx` has the context in bits 12:0, the virtual page bits VA_W-1:13, the inverted size code in bits 57:56, the real flag in bit 60 and the partition in bits 63:61. All other bits are zero.
- R12: A lookup is answered from the contents held before the clock edge that applies a same-cycle change. Commands have the priority `flush`, then demap, then insert: a lower-priority command in the same cycle is dropped. A hit updates used flags only in cycles with no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Invalidate every slot |
| lk_valid | input | 1 | Lookup request present (enables used-flag update) |
| lk_va | input | VA_W | Lookup virtual address |
| lk_part | input | 3 | Lookup partition |
| lk_ctx | input | 13 | Lookup context |
| lk_real | input | 1 | Lookup is a real-address access |
| lk_hit | output | 1 | A slot matched |
| lk_pa | output | PA_W | Translated physical address |
| ins_valid | input | 1 | Insert request |
| ins_auto | input | 1 | 1: choose victim, 0: use `ins_idx` |
| ins_idx | input | IDX_W | Explicit slot number |
| ins_va | input | VA_W | Virtual address of new page |
| ins_part | input | 3 | Partition of new page |
| ins_ctx | input | 13 | Context of new page |
| ins_real | input | 1 | Real flag of new page |
| ins_size | input | 2 | Page size code |
| ins_pa | input | PA_W | Physical base of new page |
| ins_lock | input | 1 | Lock flag of new page |
| dm_valid | input | 1 | Demap command present |
| dm_word | input | VA_W | Command word: page address, operation, context select, real flag |
| dm_part | input | 3 | Partition for the command |
| dm_pri_ctx | input | 13 | Primary context value |
| dm_sec_ctx | input | 13 | Secondary context value |
| rd_idx | input | IDX_W | Slot to read for diagnostics |
| rd_tag | output | 64 | Packed tag of slot `rd_idx` |

## Verification
A corrupted valid flag shows at the lookup port in the same cycle: a page that should translate misses, or a removed page still hits. A wrong used flag stays hidden until the next automatic insert. It then appears as a tag at an unexpected slot number on the diagnostic port, sometimes a whole fill of the buffer later, so the bench checks the victim slot after every automatic insert. A wrong page-size mask shows only when the offset bits of the request are non-zero, so lookups use random offsets.

// File: rtl/xlate_buf.sv
module xlate_buf #(
  parameter int ENTRIES = 48,
  parameter int VA_W    = 48,
  parameter int PA_W    = 40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 lk_valid,
  input  logic [VA_W-1:0]      lk_va,
  input  logic [2:0]           lk_part,
  input  logic [12:0]          lk_ctx,
  input  logic                 lk_real,
  output logic                 lk_hit,
  output logic [PA_W-1:0]      lk_pa,
  input  logic                 ins_valid,
  input  logic                 ins_auto,
  input  logic [$clog2(ENTRIES)-1:0] ins_idx,
  input  logic [VA_W-1:0]      ins_va,
  input  logic [2:0]           ins_part,
  input  logic [12:0]          ins_ctx,
  input  logic                 ins_real,
  input  logic [1:0]           ins_size,
  input  logic [PA_W-1:0]      ins_pa,
  input  logic                 ins_lock,
  input  logic                 dm_valid,
  input  logic [VA_W-1:0]      dm_word,
  input  logic [2:0]           dm_part,
  input  logic [12:0]          dm_pri_ctx,
  input  logic [12:0]          dm_sec_ctx,
  input  logic [$clog2(ENTRIES)-1:0] rd_idx,
  output logic [63:0]          rd_tag
);
  localparam int IDX_W = $clog2(ENTRIES);

  function automatic logic [4:0] off_bits(input logic [1:0] sz);
    case (sz)
      2'd0:    return 5'd13;
      2'd1:    return 5'd16;
      2'd2:    return 5'd22;
      default: return 5'd28;
    endcase
  endfunction

  function automatic logic [VA_W-1:0] va_keep(input logic [1:0] sz);
    return {VA_W{1'b1}} << off_bits(sz);
  endfunction

  function automatic logic [PA_W-1:0] pa_keep(input logic [1:0] sz);
    return {PA_W{1'b1}} << off_bits(sz);
  endfunction

  logic [VA_W-1:0] e_va   [ENTRIES];
  logic [PA_W-1:0] e_pa   [ENTRIES];
  logic [12:0]     e_ctx  [ENTRIES];
  logic [2:0]      e_part [ENTRIES];
  logic [1:0]      e_sz   [ENTRIES];
  logic [ENTRIES-1:0] real_q, valid, used, lock;
  logic [ENTRIES-1:0] valid_n, used_n, lock_n;
  logic [ENTRIES-1:0] lk_m, dup_m, pg_m, cx_m, al_m, kill, set_v, tgt_oh;
  logic [IDX_W-1:0]   hit_idx, vic_idx, tgt;

  wire [1:0] dm_op  = dm_word[7:6];
  wire [1:0] dm_sel = dm_word[5:4];
  wire       dm_ign = (dm_sel == 2'd2);
  wire [12:0] dm_ctx = (dm_sel == 2'd0) ? dm_pri_ctx :
                       (dm_sel == 2'd1) ? dm_sec_ctx : 13'd0;
  wire [VA_W-1:0] ins_km = va_keep(ins_size);
  wire do_ins = ins_valid && !flush && !dm_valid;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic [VA_W-1:0] km;
    assign km = va_keep(e_sz[i]);
    assign lk_m[i]  = valid[i] && e_part[i] == lk_part && e_ctx[i] == lk_ctx &&
                      real_q[i] == lk_real && ((lk_va ^ e_va[i]) & km) == '0;
    assign dup_m[i] = valid[i] && e_part[i] == ins_part && e_ctx[i] == ins_ctx &&
                      real_q[i] == ins_real && ((ins_va ^ e_va[i]) & km & ins_km) == '0;
    assign pg_m[i]  = valid[i] && e_part[i] == dm_part && e_ctx[i] == dm_ctx &&
                      real_q[i] == dm_word[9] && ((dm_word ^ e_va[i]) & km) == '0;
    assign cx_m[i]  = valid[i] && e_part[i] == dm_part && e_ctx[i] == dm_ctx;
    assign al_m[i]  = valid[i] && e_part[i] == dm_part && !lock[i];
  end

  always_comb begin
    hit_idx = '0;
    vic_idx = IDX_W'(ENTRIES - 1);
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lk_m[i]) hit_idx = IDX_W'(i);
      if (!valid[i] || !used[i]) vic_idx = IDX_W'(i);
    end
  end

  assign lk_hit = |lk_m;
  logic [PA_W-1:0] hit_pk;
  assign hit_pk = pa_keep(e_sz[hit_idx]);
  assign lk_pa  = lk_hit ? ((e_pa[hit_idx] & hit_pk) | (PA_W'(lk_va) & ~hit_pk)) : '0;

  assign tgt    = ins_auto ? vic_idx : ins_idx;
  assign tgt_oh = ENTRIES'(1) << tgt;

  always_comb begin
    case (dm_op)
      2'd0:    kill = dm_ign ? '0 : pg_m;
      2'd1:    kill = dm_ign ? '0 : cx_m;
      2'd2:    kill = al_m;
      default: kill = '0;
    endcase
  end

  always_comb begin
    valid_n = valid;
    used_n  = used;
    lock_n  = lock;
    set_v   = '0;
    if (flush) begin
      valid_n = '0;
      used_n  = '0;
    end else if (dm_valid) begin
      valid_n = valid & ~kill;
      used_n  = used & ~kill;
    end else if (ins_valid) begin
      valid_n = (valid & ~(dup_m & ~tgt_oh)) | tgt_oh;
      used_n  = (used & ~(dup_m & ~tgt_oh)) | tgt_oh;
      lock_n[tgt] = ins_lock;
      set_v   = tgt_oh;
    end else if (lk_valid && lk_hit) begin
      set_v   = ENTRIES'(1) << hit_idx;
      used_n  = used | set_v;
    end
    if (set_v != '0 && &used_n) used_n = (used_n & lock_n) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= '0;
      used  <= '0;
      lock  <= '0;
    end else begin
      valid <= valid_n;
      used  <= used_n;
      lock  <= lock_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_ins) begin
      e_va[tgt]   <= ins_va;
      e_pa[tgt]   <= ins_pa;
      e_ctx[tgt]  <= ins_ctx;
      e_part[tgt] <= ins_part;
      e_sz[tgt]   <= ins_size;
      real_q[tgt] <= ins_real;
    end
  end

  always_comb begin
    rd_tag = '0;
    rd_tag[12:0]      = e_ctx[rd_idx];
    rd_tag[VA_W-1:13] = e_va[rd_idx][VA_W-1:13];
    rd_tag[57:56]     = ~e_sz[rd_idx];
    rd_tag[60]        = real_q[rd_idx];
    rd_tag[63:61]     = e_part[rd_idx];
  end
endmodule

// File: rtl/xlate_buf_chk.sv
module xlate_buf_chk #(
  parameter int ENTRIES = 48
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush,
  input logic [ENTRIES-1:0] valid,
  input logic [ENTRIES-1:0] used,
  input logic [ENTRIES-1:0] lock,
  input logic [ENTRIES-1:0] lk_m
);
  a_r1_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid == '0 && used == '0));

  a_r6_used_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (used & ~valid) == '0);

  a_r6_full_only_if_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (&used) |-> ($countones(~lock) <= 1));

  a_r5_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_m));
endmodule

bind xlate_buf xlate_buf_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush),
  .valid(valid), .used(used), .lock(lock), .lk_m(lk_m)
);

// File: tb/tb_xlate_buf.sv
`timescale 1ns/1ps
module tb_xlate_buf;
  localparam int N = 8, VA_W = 48, PA_W = 40, IW = 3;

  logic clk = 0, rst_n = 0, flush = 0;
  logic lk_valid = 0, lk_real = 0, lk_hit;
  logic [VA_W-1:0] lk_va = '0;
  logic [2:0] lk_part = '0;
  logic [12:0] lk_ctx = '0;
  logic [PA_W-1:0] lk_pa;
  logic ins_valid = 0, ins_auto = 0, ins_real = 0, ins_lock = 0;
  logic [IW-1:0] ins_idx = '0, rd_idx = '0;
  logic [VA_W-1:0] ins_va = '0, dm_word = '0;
  logic [2:0] ins_part = '0, dm_part = '0;
  logic [12:0] ins_ctx = '0, dm_pri_ctx = '0, dm_sec_ctx = '0;
  logic [1:0] ins_size = '0;
  logic [PA_W-1:0] ins_pa = '0;
  logic dm_valid = 0;
  logic [63:0] rd_tag;

  always #10 clk = ~clk;

  xlate_buf #(.ENTRIES(N), .VA_W(VA_W), .PA_W(PA_W)) dut (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  bit s_hit;
  logic [PA_W-1:0] s_pa;

  bit mv[N], mu[N], ml[N], mw[N], mreal[N];
  logic [VA_W-1:0] mva[N];
  logic [PA_W-1:0] mpa[N];
  logic [12:0] mctx[N];
  logic [2:0] mpart[N];
  logic [1:0] msz[N];

  task automatic chk(bit ok, string r, logic [63:0] a, logic [63:0] e);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", r, a, e);
    end
  endtask

  function automatic int obits(logic [1:0] s);
    return s == 0 ? 13 : s == 1 ? 16 : s == 2 ? 22 : 28;
  endfunction
  function automatic logic [VA_W-1:0] vk(logic [1:0] s);
    return ~((VA_W'(1) << obits(s)) - 1);
  endfunction

  function automatic int m_find(logic [VA_W-1:0] va, logic [2:0] p, logic [12:0] c, bit r);
    for (int i = 0; i < N; i++)
      if (mv[i] && mpart[i] == p && mctx[i] == c && mreal[i] == r &&
          ((va ^ mva[i]) & vk(msz[i])) == 0) return i;
    return -1;
  endfunction

  function automatic logic [PA_W-1:0] m_pa(int i, logic [VA_W-1:0] va);
    logic [PA_W-1:0] lo = (PA_W'(1) << obits(msz[i])) - 1;
    return (mpa[i] & ~lo) | (va[PA_W-1:0] & lo);
  endfunction

  function automatic logic [63:0] m_tag(int i);
    logic [63:0] t = '0;
    t[12:0] = mctx[i];
    t[VA_W-1:13] = mva[i][VA_W-1:13];
    t[57:56] = ~msz[i];
    t[60] = mreal[i];
    t[63:61] = mpart[i];
    return t;
  endfunction

  task automatic bulk(int t);
    bit all = 1;
    for (int i = 0; i < N; i++) all &= mu[i];
    if (all) begin
      for (int i = 0; i < N; i++) mu[i] = mu[i] & ml[i];
      mu[t] = 1;
    end
  endtask

  task automatic model_update();
    if (flush) begin
      for (int i = 0; i < N; i++) begin mv[i] = 0; mu[i] = 0; end
    end else if (dm_valid) begin
      logic [1:0] op = dm_word[7:6], sel = dm_word[5:4];
      logic [12:0] c = sel == 0 ? dm_pri_ctx : sel == 1 ? dm_sec_ctx : 13'd0;
      for (int i = 0; i < N; i++) begin
        bit k = 0;
        if (op == 0 && sel != 2)
          k = mv[i] && mpart[i] == dm_part && mctx[i] == c && mreal[i] == dm_word[9] &&
              ((dm_word ^ mva[i]) & vk(msz[i])) == 0;
        else if (op == 1 && sel != 2) k = mpart[i] == dm_part && mctx[i] == c;
        else if (op == 2) k = mpart[i] == dm_part && !ml[i];
        if (k) begin mv[i] = 0; mu[i] = 0; end
      end
    end else if (ins_valid) begin
      int t = N - 1;
      if (ins_auto) begin
        for (int i = N - 1; i >= 0; i--) if (!mv[i] || !mu[i]) t = i;
      end else t = int'(ins_idx);
      for (int i = 0; i < N; i++)
        if (i != t && mv[i] && mpart[i] == ins_part && mctx[i] == ins_ctx && mreal[i] == ins_real &&
            ((ins_va ^ mva[i]) & vk(msz[i]) & vk(ins_size)) == 0) begin
          mv[i] = 0; mu[i] = 0;
        end
      mva[t] = ins_va; mpa[t] = ins_pa; mctx[t] = ins_ctx; mpart[t] = ins_part;
      msz[t] = ins_size; mreal[t] = ins_real; ml[t] = ins_lock;
      mv[t] = 1; mu[t] = 1; mw[t] = 1;
      bulk(t);
    end else if (lk_valid) begin
      int h = m_find(lk_va, lk_part, lk_ctx, lk_real);
      if (h >= 0) begin mu[h] = 1; bulk(h); end
    end
  endtask

  task automatic idle();
    flush = 0; lk_valid = 0; ins_valid = 0; dm_valid = 0;
  endtask

  task automatic step(string tag);
    int h;
    #2;
    s_hit = lk_hit; s_pa = lk_pa;
    if (lk_valid) begin
      h = m_find(lk_va, lk_part, lk_ctx, lk_real);
      chk(lk_hit == (h >= 0), {tag, " hit"}, 64'(lk_hit), 64'(h >= 0));
      if (h >= 0) chk(lk_pa == m_pa(h, lk_va), {tag, " pa"}, 64'(lk_pa), 64'(m_pa(h, lk_va)));
    end
    if (mw[rd_idx]) chk(rd_tag == m_tag(int'(rd_idx)), {tag, " tag"}, rd_tag, m_tag(int'(rd_idx)));
    @(posedge clk);
    model_update();
    @(negedge clk);
    idle();
  endtask

  task automatic ins(bit au, int idx, logic [VA_W-1:0] va, logic [2:0] p, logic [12:0] c,
                     bit r, logic [1:0] sz, logic [PA_W-1:0] pa, bit lk, string tag);
    ins_valid = 1; ins_auto = au; ins_idx = IW'(idx); ins_va = va; ins_part = p;
    ins_ctx = c; ins_real = r; ins_size = sz; ins_pa = pa; ins_lock = lk;
    step(tag);
  endtask

  task automatic set_look(logic [VA_W-1:0] va, logic [2:0] p, logic [12:0] c, bit r);
    lk_valid = 1; lk_va = va; lk_part = p; lk_ctx = c; lk_real = r;
  endtask

  task automatic look(logic [VA_W-1:0] va, logic [2:0] p, logic [12:0] c, bit r, string tag);
    set_look(va, p, c, r);
    step(tag);
  endtask

  task automatic dm(logic [VA_W-1:0] w, logic [2:0] p, logic [12:0] pri, logic [12:0] sec, string tag);
    dm_valid = 1; dm_word = w; dm_part = p; dm_pri_ctx = pri; dm_sec_ctx = sec;
    step(tag);
  endtask

  task automatic do_flush(string tag);
    flush = 1;
    step(tag);
  endtask

  function automatic logic [63:0] tag_at(int i);
    return 64'(dut.rd_tag) & 64'h0;
  endfunction

  task automatic read_tag(int i, output logic [63:0] t);
    rd_idx = IW'(i);
    #1;
    t = rd_tag;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] t;
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    look(48'h0000_1234_6000, 3'd0, 13'd0, 0, "R1");
    chk(!s_hit, "R1 reset miss", 64'(s_hit), 0);

    // R4 explicit slot, R2 64 KB translation, R11 tag layout
    ins(0, 3, 48'h00AB_CD12_0000, 3'd2, 13'h55, 0, 2'd1, 40'h12_3456_0000, 0, "R4");
    read_tag(3, t);
    chk(t == 64'h4200_00AB_CD12_0055, "R11 packed tag", t, 64'h4200_00AB_CD12_0055);
    look(48'h00AB_CD12_3456, 3'd2, 13'h55, 0, "R2");
    chk(s_hit && s_pa == 40'h12_3456_3456, "R2 64K pa", 64'(s_pa), 64'h12_3456_3456);
    look(48'h00AB_CD12_3456, 3'd2, 13'h56, 0, "R2");
    chk(!s_hit, "R2 ctx mismatch", 64'(s_hit), 0);
    ins(0, 5, 48'h0000_3000_0000, 3'd0, 13'h1, 1, 2'd3, 40'h00_5000_0000, 0, "R4");
    look(48'h0000_3ABC_DEF0, 3'd0, 13'h1, 1, "R2");
    chk(s_hit && s_pa == 40'h00_5ABC_DEF0, "R2 256M pa", 64'(s_pa), 64'h00_5ABC_DEF0);

    // R3 fill order, R6 wrap of used flags
    do_flush("R1");
    look(48'h00AB_CD12_3456, 3'd2, 13'h55, 0, "R1");
    chk(!s_hit, "R1 flush miss", 64'(s_hit), 0);
    for (int i = 0; i < N; i++) begin
      ins(1, 0, 48'h0001_0000_0000 + (48'(i) << 13), 3'd1, 13'd7, 0, 2'd0, 40'(i) << 13, 0, "R3");
      read_tag(i, t);
      chk(t[47:13] == 35'(48'h0001_0000_0000 + (48'(i) << 13) >> 13), "R3 fill slot", t, 64'(i));
    end
    ins(1, 0, 48'h0002_0000_0000, 3'd1, 13'd7, 0, 2'd0, 40'h0, 0, "R6");
    read_tag(0, t);
    chk(t[47:13] == 35'(48'h0002_0000_0000 >> 13), "R6 wrap to slot 0", t, 0);
    look(48'h0001_0000_4000, 3'd1, 13'd7, 0, "R6");
    ins(1, 0, 48'h0003_0000_0000, 3'd1, 13'd7, 0, 2'd0, 40'h0, 0, "R6");
    read_tag(1, t);
    chk(t[47:13] == 35'(48'h0003_0000_0000 >> 13), "R6 next unused slot 1", t, 1);
    ins(1, 0, 48'h0004_0000_0000, 3'd1, 13'd7, 0, 2'd0, 40'h0, 0, "R6");
    read_tag(3, t);
    chk(t[47:13] == 35'(48'h0004_0000_0000 >> 13), "R6 hit slot 2 skipped", t, 3);

    // R6 locked slots survive the wipe
    do_flush("R1");
    for (int i = 0; i < N; i++)
      ins(1, 0, 48'h0010_0000_0000 + (48'(i) << 13), 3'd0, 13'd2, 0, 2'd0, 40'h0, i < 2, "R6");
    ins(1, 0, 48'h0011_0000_0000, 3'd0, 13'd2, 0, 2'd0, 40'h0, 0, "R6");
    read_tag(2, t);
    chk(t[47:13] == 35'(48'h0011_0000_0000 >> 13), "R6 locked skip", t, 2);

    // R3 all locked: last slot
    do_flush("R1");
    for (int i = 0; i < N; i++)
      ins(0, i, 48'h0020_0000_0000 + (48'(i) << 13), 3'd0, 13'd3, 0, 2'd0, 40'h0, 1, "R4");
    ins(1, 0, 48'h0021_0000_0000, 3'd0, 13'd3, 0, 2'd0, 40'h0, 0, "R3");
    read_tag(N - 1, t);
    chk(t[47:13] == 35'(48'h0021_0000_0000 >> 13), "R3 last slot", t, N - 1);

    // R5 duplicate removal
    do_flush("R1");
    ins(1, 0, 48'h0000_0040_0000, 3'd0, 13'd9, 0, 2'd0, 40'h111_0000, 0, "R5");
    ins(1, 0, 48'h0000_0040_0000, 3'd0, 13'd9, 0, 2'd2, 40'h0000_800000, 0, "R5");
    look(48'h0000_0040_0123, 3'd0, 13'd9, 0, "R5");
    chk(s_hit && s_pa == 40'h0000_800123, "R5 newer wins", 64'(s_pa), 64'h0000_800123);
    ins(1, 0, 48'h0000_0040_0000, 3'd0, 13'd10, 0, 2'd0, 40'h0, 0, "R5");
    look(48'h0000_0040_0123, 3'd0, 13'd9, 0, "R5");
    chk(s_hit, "R5 other ctx kept", 64'(s_hit), 1);

    // R7 page demap
    do_flush("R1");
    ins(1, 0, 48'h0000_0002_4000, 3'd1, 13'h20, 1, 2'd0, 40'h0, 0, "R7");
    dm(48'h0000_0002_4000, 3'd1, 13'h20, 13'h0, "R7");
    look(48'h0000_0002_4000, 3'd1, 13'h20, 1, "R7");
    chk(s_hit, "R7 real flag differs", 64'(s_hit), 1);
    dm(48'h0000_0002_4000 | 48'h200, 3'd1, 13'h20, 13'h0, "R7");
    look(48'h0000_0002_4000, 3'd1, 13'h20, 1, "R7");
    chk(!s_hit, "R7 page removed", 64'(s_hit), 0);

    // R8 context demap via secondary
    ins(1, 0, 48'h0000_0100_0000, 3'd1, 13'd5, 0, 2'd0, 40'h0, 0, "R8");
    ins(1, 0, 48'h0000_0200_0000, 3'd1, 13'd5, 1, 2'd0, 40'h0, 0, "R8");
    ins(1, 0, 48'h0000_0100_0000, 3'd2, 13'd5, 0, 2'd0, 40'h0, 0, "R8");
    ins(1, 0, 48'h0000_0100_0000, 3'd1, 13'd6, 0, 2'd0, 40'h0, 0, "R8");
    dm(48'h0000_0000_0050, 3'd1, 13'd0, 13'd5, "R8");
    look(48'h0000_0200_0000, 3'd1, 13'd5, 1, "R8");
    chk(!s_hit, "R8 ctx removed", 64'(s_hit), 0);
    look(48'h0000_0100_0000, 3'd2, 13'd5, 0, "R8");
    chk(s_hit, "R8 other partition kept", 64'(s_hit), 1);
    look(48'h0000_0100_0000, 3'd1, 13'd6, 0, "R8");

    // R10 ignored select and illegal op
    dm(48'h0000_0000_0060, 3'd1, 13'd6, 13'd6, "R10");
    look(48'h0000_0100_0000, 3'd1, 13'd6, 0, "R10");
    chk(s_hit, "R10 select 2 ignored", 64'(s_hit), 1);
    dm(48'h0000_0000_00C0, 3'd1, 13'd6, 13'd6, "R10");
    look(48'h0000_0100_0000, 3'd1, 13'd6, 0, "R10");
    chk(s_hit, "R10 op 3 ignored", 64'(s_hit), 1);

    // R9 demap all keeps locked
    ins(1, 0, 48'h0000_0300_0000, 3'd1, 13'd4, 0, 2'd0, 40'h0, 1, "R9");
    dm(48'h0000_0000_00A0, 3'd1, 13'd0, 13'd0, "R9");
    look(48'h0000_0100_0000, 3'd1, 13'd6, 0, "R9");
    chk(!s_hit, "R9 unlocked removed", 64'(s_hit), 0);
    look(48'h0000_0300_0000, 3'd1, 13'd4, 0, "R9");
    chk(s_hit, "R9 locked kept", 64'(s_hit), 1);
    look(48'h0000_0100_0000, 3'd2, 13'd5, 0, "R9");

    // R12 same-cycle ordering
    set_look(48'h0000_0300_0000, 3'd1, 13'd4, 0);
    do_flush("R12");
    chk(s_hit, "R12 lookup before flush", 64'(s_hit), 1);
    set_look(48'h0000_0500_0000, 3'd0, 13'd1, 0);
    ins(1, 0, 48'h0000_0500_0000, 3'd0, 13'd1, 0, 2'd0, 40'h0, 0, "R12");
    chk(!s_hit, "R12 lookup before insert", 64'(s_hit), 0);
    look(48'h0000_0500_0000, 3'd0, 13'd1, 0, "R12");
    dm_valid = 1; dm_word = 48'hC0; dm_part = 0;
    ins(1, 0, 48'h0000_0600_0000, 3'd0, 13'd1, 0, 2'd0, 40'h0, 0, "R12");
    look(48'h0000_0600_0000, 3'd0, 13'd1, 0, "R12");
    chk(!s_hit, "R12 insert dropped under demap", 64'(s_hit), 0);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int k = $urandom % 16;
      logic [VA_W-1:0] va = (48'($urandom % 4) << 22) | (48'($urandom % 8) << 13) | 48'($urandom % 8192);
      logic [2:0] p = 3'($urandom % 2);
      logic [12:0] c = 13'($urandom % 3);
      bit r = bit'($urandom % 2);
      rd_idx = IW'($urandom % N);
      if (k < 6) set_look(va, p, c, r);
      if (k < 5) ins(($urandom % 4) != 0, $urandom % N, va, p, c, r, 2'($urandom % 4),
                     40'($urandom) << 8, ($urandom % 8) == 0, "R3");
      else if (k < 12) look(va, p, c, r, "R2");
      else if (k < 15) dm((va & ~48'h3FF) | 48'($urandom % 4) << 6 | 48'($urandom % 4) << 4 |
                          48'($urandom % 2) << 9, p, c, 13'($urandom % 3), "R7");
      else if (($urandom % 8) == 0) do_flush("R1");
      else look(va, p, c, r, "R6");
    end
    for (int i = 0; i < N; i++)
      if (mv[i]) look(mva[i], mpart[i], mctx[i], mreal[i], "R2");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule